// File: doc/BRIEF.md
# Twin-Predicated Vector Move Sequencer

The sequencer carries out one vector register move in which the source side and the destination side each have their own element mask and their own scalar or vector addressing. It walks a source element index and a destination element index separately. Each index skips lanes whose enable bit is clear. The k-th enabled source element is copied into the k-th enabled destination element, so the move acts as an ordered gather followed by an ordered scatter.

A start strobe captures the base register numbers, the vector length, both masks, both force-all-ones bits and both scalar bits. The block first checks that each base plus the vector length fits inside the register file. If either does not, it reports a trap and touches nothing. Otherwise it issues one register-file read per cycle. The register file answers one cycle later, and the block writes that data to the paired destination register in the same cycle as it arrives. A one-cycle done pulse closes the sequence.

Top module: `tpm_move_seq`

## Requirements
- R1: After reset `busy`, `done`, `trap`, `rd_en` and `wr_en` are all 0.
- R2: A start with `src_base + vl >= NREGS` or `dst_base + vl >= NREGS` raises `trap` for exactly one cycle, in the cycle after the start. It issues no read, no write and no `done`, and leaves the register file unchanged.
- R3: Lane i of a side is enabled when i < `vl` and either that side's force bit is 1 or bit i of its mask is 1. Mask bit 0 is lane 0.
- R4: The k-th enabled source lane is copied to the k-th enabled destination lane, counting from lane 0 upward. Source lanes left over after the last enabled destination lane are dropped. Destination lanes left over after the last enabled source lane are not written. The number of writes equals the smaller of the two enabled-lane counts.
- R5: A side in vector mode addresses register base + lane. A side in scalar mode (scalar bit = 1) addresses its base register for every lane.
- R6: With a forced, scalar source and a forced, vector destination, the source base register is copied into all `vl` destination registers (a splat).
- R7: A destination mask with a single set bit, at lane j < `vl`, writes only register `dst_base + j`. It receives the first enabled source element.
- R8: At most one read and one write are issued per cycle. Each write occurs in the cycle after its read and carries `rd_data` from that cycle.
- R9: `done` pulses for one cycle, K+2 cycles after the start edge, where K is the number of writes. `busy` is high from the cycle after the start until `done`.
- R10: A start while `busy` is high is ignored. The running move completes with its own captured operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a move (sampled while idle) |
| src_base | input | REG_W | First source register number |
| dst_base | input | REG_W | First destination register number |
| vl | input | VL_W | Vector length, 0 to MAXVL |
| src_mask | input | MAXVL | Source lane enables |
| dst_mask | input | MAXVL | Destination lane enables |
| src_all | input | 1 | Force all source lanes enabled |
| dst_all | input | 1 | Force all destination lanes enabled |
| src_scalar | input | 1 | Source address does not advance |
| dst_scalar | input | 1 | Destination address does not advance |
| rd_en | output | 1 | Register read request |
| rd_addr | output | REG_W | Register to read |
| rd_data | input | DATA_W | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Register write request |
| wr_addr | output | REG_W | Register to write |
| wr_data | output | DATA_W | Data to write |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | One-cycle range-fault pulse |

## Verification
The assertions watch the control handshake on every cycle:
- a trap never coincides with activity or with `done`;
- every write follows a read;
- reads occur only while busy;
- `done` is a single pulse that marks the fall of `busy`;
- a start while busy never produces a trap.

Which lanes pair with which, the effect of scalar addressing, splats and single-lane masks, and the exact K+2 latency can only be shown by the bench's scenarios. The bench compares the register file contents and the write counts against a reference model of the pairing.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // A lane is live when it lies below the length and is enabled or forced.
    function automatic logic lane_on(input logic force_all, input logic bit_in,
                                     input int unsigned lane, input int unsigned len);
        return (lane < len) && (force_all || bit_in);
    endfunction

endpackage

// File: rtl/tpm_lane_enable.sv
module tpm_lane_enable
    import tpm_pkg::*;
#(
    parameter int unsigned N    = 8,
    parameter int unsigned VL_W = 4
) (
    input  logic [N-1:0]    raw,
    input  logic            force_all,
    input  logic [VL_W-1:0] vl,
    output logic [N-1:0]    en
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        assign en[g] = lane_on(force_all, raw[g], g, 32'(vl));
    end
endmodule

// File: rtl/tpm_elem_scan.sv
module tpm_elem_scan #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 4
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] from,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Lowest enabled lane at or above 'from'.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (mask[i] && ($unsigned(i) >= 32'(from))) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tpm_range_check.sv
module tpm_range_check #(
    parameter int unsigned NREGS = 32,
    parameter int unsigned REG_W = 5,
    parameter int unsigned VL_W  = 4
) (
    input  logic [REG_W-1:0] src_base,
    input  logic [REG_W-1:0] dst_base,
    input  logic [VL_W-1:0]  vl,
    output logic             bad
);
    assign bad = ((32'(src_base) + 32'(vl)) >= NREGS) ||
                 ((32'(dst_base) + 32'(vl)) >= NREGS);
endmodule

// File: rtl/tpm_move_seq.sv
module tpm_move_seq
    import tpm_pkg::*;
#(
    parameter  int unsigned NREGS  = 32,
    parameter  int unsigned MAXVL  = 8,
    parameter  int unsigned DATA_W = 32,
    localparam int unsigned REG_W  = $clog2(NREGS),
    localparam int unsigned VL_W   = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [REG_W-1:0]  src_base,
    input  logic [REG_W-1:0]  dst_base,
    input  logic [VL_W-1:0]   vl,
    input  logic [MAXVL-1:0]  src_mask,
    input  logic [MAXVL-1:0]  dst_mask,
    input  logic              src_all,
    input  logic              dst_all,
    input  logic              src_scalar,
    input  logic              dst_scalar,
    output logic              rd_en,
    output logic [REG_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              trap
);
    seq_state_e       st_q;
    logic [MAXVL-1:0] s_en_w, d_en_w, s_en_q, d_en_q;
    logic [VL_W-1:0]  s_idx_q, d_idx_q, s_nxt, d_nxt;
    logic             s_found, d_found, pair_ok, range_bad;
    logic [REG_W-1:0] s_base_q, d_base_q, d_target;
    logic             s_scal_q, d_scal_q;
    logic             wr_en_q, done_q, trap_q;
    logic [REG_W-1:0] wr_addr_q;

    tpm_lane_enable #(.N(MAXVL), .VL_W(VL_W)) i_src_lanes (
        .raw(src_mask), .force_all(src_all), .vl(vl), .en(s_en_w));
    tpm_lane_enable #(.N(MAXVL), .VL_W(VL_W)) i_dst_lanes (
        .raw(dst_mask), .force_all(dst_all), .vl(vl), .en(d_en_w));

    tpm_range_check #(.NREGS(NREGS), .REG_W(REG_W), .VL_W(VL_W)) i_range (
        .src_base(src_base), .dst_base(dst_base), .vl(vl), .bad(range_bad));

    tpm_elem_scan #(.N(MAXVL), .IW(VL_W)) i_src_scan (
        .mask(s_en_q), .from(s_idx_q), .found(s_found), .idx(s_nxt));
    tpm_elem_scan #(.N(MAXVL), .IW(VL_W)) i_dst_scan (
        .mask(d_en_q), .from(d_idx_q), .found(d_found), .idx(d_nxt));

    assign pair_ok  = (st_q == ST_RUN) && s_found && d_found;
    assign rd_en    = pair_ok;
    assign rd_addr  = s_base_q + (s_scal_q ? '0 : REG_W'(s_nxt));
    assign d_target = d_base_q + (d_scal_q ? '0 : REG_W'(d_nxt));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            s_en_q    <= '0;
            d_en_q    <= '0;
            s_idx_q   <= '0;
            d_idx_q   <= '0;
            s_base_q  <= '0;
            d_base_q  <= '0;
            s_scal_q  <= 1'b0;
            d_scal_q  <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            done_q    <= 1'b0;
            trap_q    <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            trap_q  <= 1'b0;
            wr_en_q <= pair_ok;
            if (pair_ok) begin
                wr_addr_q <= d_target;
            end
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        if (range_bad) begin
                            trap_q <= 1'b1;
                        end else begin
                            st_q     <= ST_RUN;
                            s_en_q   <= s_en_w;
                            d_en_q   <= d_en_w;
                            s_idx_q  <= '0;
                            d_idx_q  <= '0;
                            s_base_q <= src_base;
                            d_base_q <= dst_base;
                            s_scal_q <= src_scalar;
                            d_scal_q <= dst_scalar;
                        end
                    end
                end
                ST_RUN: begin
                    if (pair_ok) begin
                        s_idx_q <= s_nxt + 1'b1;
                        d_idx_q <= d_nxt + 1'b1;
                    end else begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign wr_en   = wr_en_q;
    assign wr_addr = wr_addr_q;
    assign wr_data = rd_data;
    assign busy    = (st_q == ST_RUN);
    assign done    = done_q;
    assign trap    = trap_q;
endmodule

// File: rtl/tpm_move_seq_chk.sv
module tpm_move_seq_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic rd_en,
    input logic wr_en,
    input logic busy,
    input logic done,
    input logic trap
);
    // R2
    trap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        trap |-> (!busy && !wr_en && !rd_en && !done));

    // R8
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(rd_en));

    // R8
    rd_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> busy);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> !trap);
endmodule

bind tpm_move_seq tpm_move_seq_chk i_tpm_move_seq_chk (
    .clk(clk), .rst(rst), .start(start), .rd_en(rd_en), .wr_en(wr_en),
    .busy(busy), .done(done), .trap(trap));

// File: tb/test_tpm_move_seq.sv
module test_tpm_move_seq;
    localparam int NREGS = 32;
    localparam int MAXVL = 8;
    localparam int DW    = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [4:0] sb = '0, db = '0;
    logic [3:0] vl = '0;
    logic [7:0] sm = '0, dm = '0;
    logic sa = 1'b0, da = 1'b0, ss = 1'b0, ds = 1'b0;
    logic rd_en, wr_en, busy, done, trap;
    logic [4:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;

    logic [DW-1:0] mem [NREGS];
    logic [DW-1:0] refm [NREGS];
    logic [DW-1:0] expm [NREGS];
    int wr_cnt = 0;
    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    tpm_move_seq #(.NREGS(NREGS), .MAXVL(MAXVL), .DATA_W(DW)) i_tpm_move_seq (
        .clk(clk), .rst(rst), .start(start), .src_base(sb), .dst_base(db),
        .vl(vl), .src_mask(sm), .dst_mask(dm), .src_all(sa), .dst_all(da),
        .src_scalar(ss), .dst_scalar(ds), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .trap(trap));

    // Register file model with one-cycle read latency.
    always @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_en) rd_data <= mem[rd_addr];
        if (wr_en) wr_cnt <= wr_cnt + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d exp<=150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, expv);
        end
    endtask

    function automatic bit lane_live(input logic frc, input logic [7:0] m,
                                     input int i, input int len);
        return (i < len) && (frc || m[i]);
    endfunction

    task automatic run_case(input logic [4:0] s_b, input logic [4:0] d_b,
                            input int len, input logic [7:0] s_m, input logic [7:0] d_m,
                            input logic s_a, input logic d_a, input logic s_s,
                            input logic d_s, input bit poke, input string req);
        int si, di, pairs, w0, done_at, done_n, trap_at, trap_n, bad;
        bit exp_trap;
        for (int r = 0; r < NREGS; r++) begin
            mem[r]  = $urandom();
            refm[r] = mem[r];
            expm[r] = mem[r];
        end
        exp_trap = (int'(s_b) + len >= NREGS) || (int'(d_b) + len >= NREGS);
        pairs = 0;
        if (!exp_trap) begin
            si = 0;
            di = 0;
            forever begin
                while (si < len && !lane_live(s_a, s_m, si, len)) si++;
                while (di < len && !lane_live(d_a, d_m, di, len)) di++;
                if (si >= len || di >= len) break;
                expm[d_s ? int'(d_b) : int'(d_b) + di] = refm[s_s ? int'(s_b) : int'(s_b) + si];
                pairs++;
                si++;
                di++;
            end
        end
        sb = s_b; db = d_b; vl = 4'(len); sm = s_m; dm = d_m;
        sa = s_a; da = d_a; ss = s_s; ds = d_s;
        start = 1'b1;
        w0 = wr_cnt;
        done_at = -1; done_n = 0; trap_at = -1; trap_n = 0;
        for (int c = 1; c <= 30; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (poke && c == 3) begin
                db = 5'd30;
                vl = 4'd8;
                start = 1'b1;
            end
            if (done) begin done_n++; if (done_at < 0) done_at = c; end
            if (trap) begin trap_n++; if (trap_at < 0) trap_at = c; end
        end
        bad = 0;
        for (int r = 0; r < NREGS; r++) if (mem[r] !== expm[r]) bad++;
        if (exp_trap) begin
            check(trap_n == 1 && trap_at == 1, "R2", {req, " trap pulse cycle"}, trap_at, 1);
            check(done_n == 0, "R2", {req, " no done on trap"}, done_n, 0);
            check(wr_cnt - w0 == 0, "R2", {req, " no writes on trap"}, wr_cnt - w0, 0);
        end else begin
            check(trap_n == 0, req, "unexpected trap", trap_n, 0);
            check(done_n == 1, "R9", {req, " done pulse count"}, done_n, 1);
            check(done_at == pairs + 2, "R9", {req, " done latency"}, done_at, pairs + 2);
            check(wr_cnt - w0 == pairs, "R4", {req, " write count"}, wr_cnt - w0, pairs);
        end
        check(bad == 0, req, "register file mismatches", bad, 0);
    endtask

    initial begin
        void'($urandom(32'd20211211));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!busy && !done && !trap && !rd_en && !wr_en, "R1", "idle after reset",
              {busy, done, trap, rd_en, wr_en}, 0);

        // Directed corner cases.
        run_case(5'd3, 5'd16, 8, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        run_case(5'd2, 5'd16, 8, 8'b0110_0000, 8'b0000_0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        run_case(5'd4, 5'd20, 6, 8'h3F, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
        run_case(5'd4, 5'd20, 5, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
        run_case(5'd0, 5'd16, 8, 8'b1010_1010, 8'b0000_1111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        run_case(5'd0, 5'd16, 8, 8'b0000_0011, 8'b1111_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        run_case(5'd1, 5'd17, 3, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        run_case(5'd1, 5'd17, 0, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        run_case(5'd28, 5'd0, 4, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        run_case(5'd0, 5'd25, 7, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        run_case(5'd23, 5'd0, 8, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        run_case(5'd0, 5'd16, 8, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        run_case(5'd6, 5'd18, 8, 8'h81, 8'h18, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");

        // Constrained random moves, source and destination regions kept apart.
        for (int n = 0; n < 60; n++) begin
            logic [4:0] rs, rdb;
            if ($urandom_range(0, 5) == 0) begin
                rs  = 5'($urandom_range(20, 31));
                rdb = 5'($urandom_range(0, 7));
            end else begin
                rs  = 5'($urandom_range(0, 8));
                rdb = 5'($urandom_range(16, 24));
            end
            run_case(rs, rdb, int'($urandom_range(0, 8)), 8'($urandom()), 8'($urandom()),
                     1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
                     1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
                     1'b0, "R4");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule